// File: doc/BRIEF.md
# DMA Chunked Copy Engine

This block moves data for a single DMA channel. Control logic stages a configuration word, a byte count, a destination address and a source address, then pulses a start input. The engine checks the staged request, copies it into working registers, and moves the bytes from source to destination over a simple memory request interface. Each chunk is one read followed by one write of the same bytes.

The chunk size is a power of two taken from a log2 size field in the configuration word, and it never exceeds 64 bytes. Full chunks go first. A byte count that is not a multiple of the chunk size ends with one shorter chunk. If the request has a zero count, or if its read and write size fields disagree, the engine posts a result at once and makes no memory requests. When the request's repeat bit is set, the working registers return to their staged values at completion, so the same transfer can be started again.

The working registers and the sticky done and error flags are visible at the ports. A register interface can show them to software and clear its run bit when the clear-run strobe fires.

Top module: `dma_chunk_mover`

## Requirements
- R1: A start with a staged byte count of zero posts success directly. Done is set, clear-run pulses with finish, no read or write request is made, and the working registers and the error flag keep their values. This case takes priority over a size mismatch.
- R2: The write size field is config bits 27:24 and the read size field is bits 31:28. A start with a non-zero count and unequal fields makes no memory request. It sets the error flag, leaves done and the working registers unchanged, and posts finish without clear-run.
- R3: Every chunk length equals min(2^min(size,6), remaining bytes). It is therefore between 1 and 64.
- R4: An accepted start with a non-zero count and equal sizes clears done and error. It loads the staged config, count, destination and source into the working registers, and the first read request appears in the next cycle.
- R5: Each chunk is a read at the working source, then a write of the same length at the working destination. When the write is accepted, both addresses advance by the length and the working count drops by it.
- R6: A byte count that is not a multiple of the chunk size ends with one chunk of (count mod chunk size) bytes.
- R7: With config bit 2 (repeat) set, the working count, destination and source return to their staged values at completion. Without it the working count ends at zero and the addresses end one past the last byte moved.
- R8: After the final write is accepted, done is set, the error flag is cleared, and finish and clear-run pulse together in the next cycle.
- R9: Busy rises in the cycle after an accepted start and stays high through the single finish cycle. Start is ignored while busy is high. After reset, busy, finish, done, error and both requests are low.
- R10: A request keeps its address and length until it is accepted. The write data equals the read data captured when the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| cfg_i | input | 32 | Staged config: repeat bit 2, write size 27:24, read size 31:28 |
| bytes_i | input | CNT_W | Staged byte count |
| dst_i | input | ADDR_W | Staged destination address |
| src_i | input | ADDR_W | Staged source address |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_len_o | output | MAX_LG+1 | Read length in bytes |
| rd_ready_i | input | 1 | Read accepted; read data is valid in the same cycle |
| rd_data_i | input | 8*2^MAX_LG | Read data, byte 0 in the low bits |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_len_o | output | MAX_LG+1 | Write length in bytes |
| wr_data_o | output | 8*2^MAX_LG | Write data, byte 0 in the low bits |
| wr_ready_i | input | 1 | Write accepted |
| xcfg_o | output | 32 | Working config |
| xbytes_o | output | CNT_W | Working remaining count |
| xdst_o | output | ADDR_W | Working destination |
| xsrc_o | output | ADDR_W | Working source |
| busy_o | output | 1 | Transfer in progress, including the finish cycle |
| fin_o | output | 1 | One-cycle result strobe |
| done_o | output | 1 | Sticky done flag |
| err_o | output | 1 | Sticky error flag |
| run_clr_o | output | 1 | Strobe telling the register interface to clear its run bit |

## Verification
The hardest situation to reach is a handshake that stalls at every possible point: a read or write request held for several cycles, next to a chunk boundary and the shorter final chunk. The stimulus drives both ready inputs from a free-running pseudo-random sequence so that stalls fall at varied points. The byte counts are chosen to leave remainders under both small and capped chunk sizes. Two other paths are hard to reach: the start that posts at once, and the start that arrives while a transfer is still running. The stimulus reaches them by holding start high for one cycle mid-transfer, and by pairing a zero count with mismatched size fields.

// File: rtl/dmacp_pkg.sv
package dmacp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_POST} mover_st_e;
  localparam int CFG_W   = 32;
  localparam int WSZ_LSB = 24;
  localparam int RSZ_LSB = 28;
  localparam int SZ_W    = 4;
  localparam int RPT_BIT = 2;
endpackage

// File: rtl/dmacp_size_dec.sv
module dmacp_size_dec
  import dmacp_pkg::*;
#(
  parameter int MAX_LG = 6,
  localparam int LG_W  = $clog2(MAX_LG + 1)
) (
  input  logic [CFG_W-1:0] cfg,
  output logic             mismatch,
  output logic [LG_W-1:0]  lg
);
  logic [SZ_W-1:0] wsz, rsz;

  function automatic logic [LG_W-1:0] cap_lg(input logic [SZ_W-1:0] fld);
    if (int'(fld) > MAX_LG) return LG_W'(MAX_LG);
    return LG_W'(fld);
  endfunction

  assign wsz      = cfg[WSZ_LSB +: SZ_W];
  assign rsz      = cfg[RSZ_LSB +: SZ_W];
  assign mismatch = (wsz != rsz);
  assign lg       = cap_lg(wsz);
endmodule

// File: rtl/dmacp_chunk_len.sv
module dmacp_chunk_len #(
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LG_W  = $clog2(MAX_LG + 1),
  localparam int LEN_W = MAX_LG + 1
) (
  input  logic [CNT_W-1:0] remain,
  input  logic [LG_W-1:0]  lg,
  output logic [LEN_W-1:0] len,
  output logic             is_last
);
  function automatic logic [LEN_W-1:0] pick_len(input logic [CNT_W-1:0] rem,
                                                input logic [LG_W-1:0] l);
    logic [CNT_W-1:0] full;
    full = CNT_W'(1) << l;
    if (rem < full) return LEN_W'(rem);
    return LEN_W'(full);
  endfunction

  assign len     = pick_len(remain, lg);
  assign is_last = (remain <= CNT_W'(len));
endmodule

// File: rtl/dmacp_hold_buf.sv
module dmacp_hold_buf #(
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/dma_chunk_mover.sv
module dma_chunk_mover
  import dmacp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LG_W   = $clog2(MAX_LG + 1),
  localparam int LEN_W  = MAX_LG + 1,
  localparam int DATA_W = 8 * (1 << MAX_LG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [CNT_W-1:0]  bytes_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] src_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [LEN_W-1:0]  rd_len_o,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic [CFG_W-1:0]  xcfg_o,
  output logic [CNT_W-1:0]  xbytes_o,
  output logic [ADDR_W-1:0] xdst_o,
  output logic [ADDR_W-1:0] xsrc_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic              done_o,
  output logic              err_o,
  output logic              run_clr_o
);
  mover_st_e         st;
  logic [LG_W-1:0]   lg_q, stage_lg;
  logic              stage_mismatch;
  logic [CNT_W-1:0]  orig_bytes;
  logic [ADDR_W-1:0] orig_dst, orig_src;
  logic              ok_q;
  logic [LEN_W-1:0]  cur_len;
  logic              cur_last;

  // named events for the checker
  logic start_take, rd_fire, wr_fire, zero_req, bad_req;
  assign start_take = (st == ST_IDLE) && start_i;
  assign zero_req   = start_take && (bytes_i == '0);
  assign bad_req    = start_take && !zero_req && stage_mismatch;
  assign rd_fire    = (st == ST_RD) && rd_ready_i;
  assign wr_fire    = (st == ST_WR) && wr_ready_i;

  dmacp_size_dec #(.MAX_LG(MAX_LG)) u_size (
    .cfg(cfg_i), .mismatch(stage_mismatch), .lg(stage_lg)
  );

  dmacp_chunk_len #(.CNT_W(CNT_W), .MAX_LG(MAX_LG)) u_len (
    .remain(xbytes_o), .lg(lg_q), .len(cur_len), .is_last(cur_last)
  );

  dmacp_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(rd_fire), .din(rd_data_i), .dout(wr_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      lg_q       <= '0;
      xcfg_o     <= '0;
      xbytes_o   <= '0;
      xdst_o     <= '0;
      xsrc_o     <= '0;
      orig_bytes <= '0;
      orig_dst   <= '0;
      orig_src   <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (zero_req) begin
            done_o <= 1'b1;
            ok_q   <= 1'b1;
            st     <= ST_POST;
          end else if (bad_req) begin
            err_o <= 1'b1;
            ok_q  <= 1'b0;
            st    <= ST_POST;
          end else if (start_take) begin
            xcfg_o     <= cfg_i;
            xbytes_o   <= bytes_i;
            xdst_o     <= dst_i;
            xsrc_o     <= src_i;
            orig_bytes <= bytes_i;
            orig_dst   <= dst_i;
            orig_src   <= src_i;
            lg_q       <= stage_lg;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            st         <= ST_RD;
          end
        end
        ST_RD: if (rd_fire) st <= ST_WR;
        ST_WR: begin
          if (wr_fire) begin
            xsrc_o   <= xsrc_o + ADDR_W'(cur_len);
            xdst_o   <= xdst_o + ADDR_W'(cur_len);
            xbytes_o <= xbytes_o - CNT_W'(cur_len);
            if (cur_last) begin
              if (xcfg_o[RPT_BIT]) begin
                xbytes_o <= orig_bytes;
                xdst_o   <= orig_dst;
                xsrc_o   <= orig_src;
              end
              done_o <= 1'b1;
              ok_q   <= 1'b1;
              st     <= ST_POST;
            end else begin
              st <= ST_RD;
            end
          end
        end
        ST_POST: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st == ST_RD);
  assign rd_addr_o = xsrc_o;
  assign rd_len_o  = cur_len;
  assign wr_req_o  = (st == ST_WR);
  assign wr_addr_o = xdst_o;
  assign wr_len_o  = cur_len;
  assign busy_o    = (st != ST_IDLE);
  assign fin_o     = (st == ST_POST);
  assign run_clr_o = fin_o && ok_q;
endmodule

// File: rtl/dmacp_checker.sv
module dmacp_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MAX_LG = 6,
  localparam int LEN_W = MAX_LG + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_take,
  input logic              zero_req,
  input logic              bad_req,
  input logic              rd_fire,
  input logic              wr_fire,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LEN_W-1:0]  rd_len,
  input logic              wr_req,
  input logic [LEN_W-1:0]  wr_len,
  input logic [CNT_W-1:0]  xbytes,
  input logic              rpt,
  input logic              busy,
  input logic              fin,
  input logic              done,
  input logic              err,
  input logic              run_clr
);
  localparam int MAX_BYTES = 1 << MAX_LG;

  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> fin && done && run_clr && !rd_req) else $error("zero count"); // R1
  AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> fin && err && !run_clr && !rd_req) else $error("mismatch"); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_len != '0) && (int'(rd_len) <= MAX_BYTES)) else $error("len"); // R3
  AST_START_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && !zero_req && !bad_req) |=> rd_req && !done && !err) else $error("start"); // R4
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> wr_req && (wr_len == $past(rd_len))) else $error("rd->wr"); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)) else $error("overlap"); // R5
  AST_COUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rpt) |=> xbytes == $past(xbytes) - CNT_W'($past(wr_len))) else $error("count"); // R5
  AST_RUNCLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |-> fin && done) else $error("runclr"); // R8
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin && !busy) else $error("fin"); // R9
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> busy) else $error("busy"); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_fire) |=> rd_req && $stable(rd_addr) && $stable(rd_len)) else $error("hold"); // R10
endmodule

bind dma_chunk_mover dmacp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LG(MAX_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_take(start_take), .zero_req(zero_req), .bad_req(bad_req),
  .rd_fire(rd_fire), .wr_fire(wr_fire), .rd_req(rd_req_o), .rd_addr(rd_addr_o),
  .rd_len(rd_len_o), .wr_req(wr_req_o), .wr_len(wr_len_o), .xbytes(xbytes_o),
  .rpt(xcfg_o[2]), .busy(busy_o), .fin(fin_o), .done(done_o), .err(err_o),
  .run_clr(run_clr_o)
);

// File: tb/dma_chunk_mover_bench.sv
module dma_chunk_mover_bench;
  localparam int AW = 32;
  localparam int CW = 32;
  localparam int DW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [CW-1:0] bytes_i = '0;
  logic [AW-1:0] dst_i = '0, src_i = '0;
  logic rd_req_o, wr_req_o, rd_ready_i = 1'b0, wr_ready_i = 1'b0;
  logic [AW-1:0] rd_addr_o, wr_addr_o, xdst_o, xsrc_o;
  logic [6:0] rd_len_o, wr_len_o;
  logic [DW-1:0] rd_data_i = '0, wr_data_o;
  logic [31:0] xcfg_o;
  logic [CW-1:0] xbytes_o;
  logic busy_o, fin_o, done_o, err_o, run_clr_o;

  always #2.5 clk = ~clk;

  dma_chunk_mover u_dma_chunk_mover (.*);

  int total = 0, bad = 0;
  logic [7:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_ph = 0;
  logic [31:0] m_xcfg = 0;
  longint m_xb = 0, m_xd = 0, m_xs = 0, m_ob = 0, m_od = 0, m_os = 0;
  logic m_done = 0, m_err = 0, m_ok = 0;

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint mlen();
    int f = int'(m_xcfg[27:24]);
    longint c = longint'(1) << ((f > 6) ? 6 : f);
    return (m_xb < c) ? m_xb : c;
  endfunction

  task automatic model_adv();
    case (m_ph)
      0: if (start_i) begin
        if (bytes_i == 0) begin m_done = 1; m_ok = 1; m_ph = 3; end
        else if (cfg_i[27:24] != cfg_i[31:28]) begin m_err = 1; m_ok = 0; m_ph = 3; end
        else begin
          m_xcfg = cfg_i; m_xb = bytes_i; m_xd = dst_i; m_xs = src_i;
          m_ob = bytes_i; m_od = dst_i; m_os = src_i;
          m_done = 0; m_err = 0; m_ph = 1;
        end
      end
      1: if (rd_ready_i) m_ph = 2;
      2: if (wr_ready_i) begin
        longint n = mlen();
        for (int i = 0; i < n; i++) begin
          check("R10 data", wr_data_o[i*8 +: 8], mem[(m_xs + i) % 1024]);
          mem[(m_xd + i) % 1024] = wr_data_o[i*8 +: 8];
        end
        m_xs += n; m_xd += n; m_xb -= n;
        if (m_xb == 0) begin
          if (m_xcfg[2]) begin m_xb = m_ob; m_xd = m_od; m_xs = m_os; end
          m_done = 1; m_ok = 1; m_ph = 3;
        end else m_ph = 1;
      end
      default: m_ph = 0;
    endcase
  endtask

  task automatic compare();
    check("R9 busy", busy_o, m_ph != 0);
    check("R9 fin", fin_o, m_ph == 3);
    check("R8 done", done_o, m_done);
    check("R2 err", err_o, m_err);
    check("R8 run_clr", run_clr_o, (m_ph == 3) && m_ok);
    check("R5 rd_req", rd_req_o, m_ph == 1);
    check("R5 wr_req", wr_req_o, m_ph == 2);
    check("R7 xbytes", xbytes_o, m_xb);
    check("R7 xsrc", xsrc_o, m_xs);
    check("R7 xdst", xdst_o, m_xd);
    check("R4 xcfg", xcfg_o, m_xcfg);
    if (m_ph == 1) begin
      check("R3 rd_len", rd_len_o, mlen());
      check("R10 rd_addr", rd_addr_o, m_xs);
    end
    if (m_ph == 2) begin
      check("R6 wr_len", wr_len_o, mlen());
      check("R5 wr_addr", wr_addr_o, m_xd);
    end
  endtask

  task automatic tick();
    model_adv();
    @(posedge clk);
    #1;
    compare();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready_i = lfsr[0] | lfsr[3];
    wr_ready_i = lfsr[5] | lfsr[9];
    for (int i = 0; i < 64; i++)
      rd_data_i[i*8 +: 8] = (i < mlen()) ? mem[(m_xs + i) % 1024] : 8'hEE;
  endtask

  function automatic logic [31:0] cfgv(int w, int r, bit rpt);
    return {r[3:0], w[3:0], 21'b0, rpt, 2'b00};
  endfunction

  task automatic run(logic [31:0] c, longint n, longint d, longint s, bit poke);
    cfg_i = c; bytes_i = CW'(n); dst_i = AW'(d); src_i = AW'(s);
    start_i = 1; tick(); start_i = 0;
    for (int k = 0; k < 3000 && m_ph != 0; k++) begin
      if (poke && k == 4) begin
        bytes_i = 0; start_i = 1; tick(); start_i = 0;   // R9 ignored while busy
      end else tick();
    end
  endtask

  task automatic region_check(string tag, longint d, longint s, longint n);
    int diff = 0;
    for (int i = 0; i < n; i++)
      if (mem[(d + i) % 1024] !== mem[(s + i) % 1024]) diff++;
    check(tag, diff, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare();                                            // R9 reset state
    // R1: zero count wins over mismatched sizes
    run(cfgv(3, 5, 0), 0, 600, 10, 0);
    check("R1 done after zero", done_o, 1);
    check("R1 err kept", err_o, 0);
    // R2: mismatch with non-zero count
    run(cfgv(2, 3, 0), 10, 600, 10, 0);
    check("R2 err set", err_o, 1);
    check("R2 done unchanged", done_o, 1);
    check("R2 exec untouched", xbytes_o, 0);
    // R3/R6: 8-byte chunks with remainder 4
    run(cfgv(3, 3, 0), 20, 600, 10, 0);
    region_check("R6 copy 20", 600, 10, 20);
    check("R4 err cleared", err_o, 0);
    check("R7 no repeat count", xbytes_o, 0);
    check("R7 no repeat src", xsrc_o, 30);
    // R3: size 9 capped to 64, remainder 22
    run(cfgv(9, 9, 0), 150, 700, 100, 0);
    region_check("R3 copy 150", 700, 100, 150);
    // R3: one-byte chunks, plus a start pulse while busy
    run(cfgv(0, 0, 0), 3, 900, 40, 1);
    region_check("R9 copy 3", 900, 40, 3);
    // R7: repeat reloads the working registers
    run(cfgv(2, 2, 1), 10, 950, 200, 0);
    region_check("R7 copy 10", 950, 200, 10);
    check("R7 repeat count", xbytes_o, 10);
    check("R7 repeat src", xsrc_o, 200);
    check("R7 repeat dst", xdst_o, 950);
    // R6: exact multiple, no remainder chunk
    run(cfgv(4, 4, 0), 32, 500, 300, 0);
    region_check("R6 copy 32", 500, 300, 32);
    tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule